// File: doc/BRIEF.md
# Load-store byte lane aligner

This block sits between the load/store stage of a 32-bit core and a data memory that is one word wide. It receives a memory opcode, an effective address that was computed upstream, and the store operand. For stores it steers the low byte, the low halfword or the whole operand onto the byte lanes the address selects, and it produces a four-bit byte-write enable. For loads it asserts a read strobe and remembers the access size, the extension mode and the byte offset. One cycle later it takes the word the memory returns, picks out the addressed byte or halfword, and widens the value with sign or zero fill.

Memory is big-endian: byte offset 0 of a word occupies bits 31:24, and write-enable bit 3 guards those bits. Halfword accesses at an odd address, and word accesses at an address that is not a multiple of four, are flagged as misaligned. Such an access produces no write enable and no read. The word address passed to the memory is the request address with its two low bits cleared.

Top module: `lsa_aligner`

## Requirements
- R1: Only these opcodes access memory: 100000 (signed byte load), 100100 (unsigned byte load), 100001 (signed halfword load), 100101 (unsigned halfword load), 100011 (word load), 101000 (byte store), 101001 (halfword store) and 101011 (word store). Any other opcode produces no write enable, no read strobe, no misalign flag and no load result.
- R2: Byte order is big-endian. Byte offset 0 maps to data bits 31:24 and to `mem_we[3]`, and byte offset 3 maps to bits 7:0 and to `mem_we[0]`.
- R3: A byte store enables exactly bit `mem_we[3-offset]`. A halfword store enables 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store enables 4'b1111.
- R4: Store data is replicated across the lanes: operand bits 7:0 go to all four lanes for a byte, operand bits 15:0 go to both halves for a halfword, and the operand passes unchanged for a word.
- R5: A halfword access with address bit 0 set, or a word access with either of address bits 1:0 set, raises `misalign` in the same cycle and suppresses both `mem_we` and `mem_re`. Byte accesses are never misaligned.
- R6: A byte load returns the byte at the registered offset, sign-extended for opcode 100000 and zero-extended for opcode 100100.
- R7: A halfword load returns bits 31:16 at offset 0 or bits 15:0 at offset 2, sign-extended for opcode 100001 and zero-extended for opcode 100101.
- R8: A word load returns the memory word unchanged.
- R9: `ld_valid` is high in the cycle after every cycle with `mem_re` high, and only then. `ld_data` is formed from `mem_rdata` in that cycle, using the context registered with the request, so that loads may issue back to back.
- R10: `mem_re` is high in the request cycle for an aligned load, and `mem_addr` equals `req_addr` with bits 1:0 forced to zero.
- R11: While `req_valid` is low, the opcode and address are ignored: `mem_we` is 0, `mem_re` and `misalign` are low, and `ld_valid` is low in the next cycle.
- R12: Asynchronous reset clears the pending-load context, so `ld_valid` is low during reset and in the first cycle after it, even if a load was presented as reset was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A memory request is present this cycle |
| req_op | input | 6 | Primary opcode field of the instruction |
| req_addr | input | ADDR_W | Effective byte address |
| req_wdata | input | 4*BYTE_W | Store operand (source register value) |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_we | output | 4 | Per-lane write enable, bit 3 = bits 31:24 |
| mem_wdata | output | 4*BYTE_W | Lane-steered store data |
| mem_re | output | 1 | Read strobe for an aligned load |
| misalign | output | 1 | Request address violates the access alignment |
| mem_rdata | input | 4*BYTE_W | Word returned by memory one cycle after `mem_re` |
| ld_valid | output | 1 | Load result is present this cycle |
| ld_data | output | 4*BYTE_W | Aligned and extended load result |

## Verification
The bench builds the block with its defaults, ADDR_W = 32 and BYTE_W = 8, so opcode semantics and the extension boundaries land exactly on 8/16/32-bit values. These defaults place sign bits such as 0x80 and 0xA5 next to positive values such as 0x7F and 0x5A in one returned word, so each offset shows sign and zero fill. An address whose upper bits are non-zero shows that only bits 1:0 are cleared. Back-to-back loads and a load cut off by reset exercise the registered context, and illegal opcodes next to legal ones exercise the decode.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;

    // Primary opcode values of the memory instructions handled here
    localparam logic [5:0] OP_LDB_S = 6'b100000;
    localparam logic [5:0] OP_LDH_S = 6'b100001;
    localparam logic [5:0] OP_LDW   = 6'b100011;
    localparam logic [5:0] OP_LDB_U = 6'b100100;
    localparam logic [5:0] OP_LDH_U = 6'b100101;
    localparam logic [5:0] OP_STB   = 6'b101000;
    localparam logic [5:0] OP_STH   = 6'b101001;
    localparam logic [5:0] OP_STW   = 6'b101011;

    // Number of byte lanes in a memory word
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd3
    } xfer_size_e;

    // Decoded view of one opcode
    typedef struct packed {
        logic       is_load;
        logic       is_store;
        xfer_size_e size;
        logic       sext;
    } acc_dec_t;

    // Context carried from a load request to its data cycle
    typedef struct packed {
        logic       vld;
        xfer_size_e size;
        logic       sext;
        logic [1:0] off;
    } ld_ctx_t;

endpackage

// File: rtl/lsa_decode.sv
`timescale 1ns/1ps
module lsa_decode
    import lsa_pkg::*;
(
    input  logic [5:0] op,
    output acc_dec_t   dec
);

    always_comb begin
        dec = '{is_load: 1'b0, is_store: 1'b0, size: SZ_WORD, sext: 1'b0};
        unique case (op)
            OP_LDB_S: dec = '{is_load: 1'b1, is_store: 1'b0, size: SZ_BYTE, sext: 1'b1};
            OP_LDB_U: dec = '{is_load: 1'b1, is_store: 1'b0, size: SZ_BYTE, sext: 1'b0};
            OP_LDH_S: dec = '{is_load: 1'b1, is_store: 1'b0, size: SZ_HALF, sext: 1'b1};
            OP_LDH_U: dec = '{is_load: 1'b1, is_store: 1'b0, size: SZ_HALF, sext: 1'b0};
            OP_LDW:   dec = '{is_load: 1'b1, is_store: 1'b0, size: SZ_WORD, sext: 1'b0};
            OP_STB:   dec = '{is_load: 1'b0, is_store: 1'b1, size: SZ_BYTE, sext: 1'b0};
            OP_STH:   dec = '{is_load: 1'b0, is_store: 1'b1, size: SZ_HALF, sext: 1'b0};
            OP_STW:   dec = '{is_load: 1'b0, is_store: 1'b1, size: SZ_WORD, sext: 1'b0};
            default:  dec = '{is_load: 1'b0, is_store: 1'b0, size: SZ_WORD, sext: 1'b0};
        endcase
    end

endmodule

// File: rtl/lsa_store_lane.sv
`timescale 1ns/1ps
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              en,
    input  logic              is_access,
    input  logic              is_store,
    input  xfer_size_e        size,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  we,
    output logic [DATA_W-1:0] lane_wdata,
    output logic              mis
);

    logic [LANES-1:0] we_raw;

    // Each lane decides its own data source and whether it is addressed
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [1:0] LANE_OFF = 2'(LANES - 1 - g);
        logic [BYTE_W-1:0] lane_d;
        logic              lane_hit;

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    lane_d   = wdata[BYTE_W-1:0];
                    lane_hit = (off == LANE_OFF);
                end
                SZ_HALF: begin
                    lane_d   = wdata[(g % 2)*BYTE_W +: BYTE_W];
                    lane_hit = (off[1] == LANE_OFF[1]);
                end
                default: begin
                    lane_d   = wdata[g*BYTE_W +: BYTE_W];
                    lane_hit = 1'b1;
                end
            endcase
        end

        assign lane_wdata[g*BYTE_W +: BYTE_W] = lane_d;
        assign we_raw[g]                      = lane_hit;
    end

    always_comb begin
        mis = 1'b0;
        if (en && is_access) begin
            unique case (size)
                SZ_HALF: mis = off[0];
                SZ_WORD: mis = |off;
                default: mis = 1'b0;
            endcase
        end
        we = (en && is_store && !mis) ? we_raw : '0;
    end

endmodule

// File: rtl/lsa_load_lane.sv
`timescale 1ns/1ps
module lsa_load_lane
    import lsa_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int HALF_W = 2 * BYTE_W
) (
    input  xfer_size_e        size,
    input  logic              sext,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);

    logic [BYTE_W-1:0] byte_v;
    logic [HALF_W-1:0] half_v;

    always_comb begin
        byte_v = '0;
        for (int i = 0; i < LANES; i++) begin
            if (off == 2'(LANES - 1 - i)) begin
                byte_v = rdata[i*BYTE_W +: BYTE_W];
            end
        end
        half_v = off[1] ? rdata[HALF_W-1:0] : rdata[DATA_W-1:HALF_W];

        unique case (size)
            SZ_BYTE: data = {{(DATA_W-BYTE_W){sext & byte_v[BYTE_W-1]}}, byte_v};
            SZ_HALF: data = {{(DATA_W-HALF_W){sext & half_v[HALF_W-1]}}, half_v};
            default: data = rdata;
        endcase
    end

endmodule

// File: rtl/lsa_aligner.sv
`timescale 1ns/1ps
module lsa_aligner
    import lsa_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [5:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic              misalign,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);

    localparam ld_ctx_t CTX_RST = '{vld: 1'b0, size: SZ_WORD, sext: 1'b0, off: 2'd0};

    acc_dec_t dec;
    ld_ctx_t  ctx_d, ctx_q;
    logic     mis;

    lsa_decode u_dec (
        .op  (req_op),
        .dec (dec)
    );

    lsa_store_lane #(.BYTE_W(BYTE_W)) u_st (
        .en         (req_valid),
        .is_access  (dec.is_load | dec.is_store),
        .is_store   (dec.is_store),
        .size       (dec.size),
        .off        (req_addr[1:0]),
        .wdata      (req_wdata),
        .we         (mem_we),
        .lane_wdata (mem_wdata),
        .mis        (mis)
    );

    // Next-state: capture load context only for an accepted aligned load
    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.vld = req_valid & dec.is_load & ~mis;
        if (ctx_d.vld) begin
            ctx_d.size = dec.size;
            ctx_d.sext = dec.sext;
            ctx_d.off  = req_addr[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= CTX_RST;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    lsa_load_lane #(.BYTE_W(BYTE_W)) u_ld (
        .size  (ctx_q.size),
        .sext  (ctx_q.sext),
        .off   (ctx_q.off),
        .rdata (mem_rdata),
        .data  (ld_data)
    );

    assign mem_addr = {req_addr[ADDR_W-1:2], 2'b00};
    assign mem_re   = ctx_d.vld;
    assign misalign = mis;
    assign ld_valid = ctx_q.vld;

endmodule

// File: rtl/lsa_aligner_chk.sv
`timescale 1ns/1ps
module lsa_aligner_chk
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [5:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_we,
    input logic              mem_re,
    input logic              misalign,
    input logic              ld_valid
);

    // R1
    rd_only_load_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (req_op[5:3] == 3'b100));

    // R1
    wr_only_store_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> (req_op[5:3] == 3'b101));

    // R3
    we_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> ($countones(mem_we) == 1 || mem_we == 4'b1100 ||
                            mem_we == 4'b0011 || mem_we == 4'b1111));

    // R5
    mis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_we == '0 && !mem_re));

    // R5
    word_mis_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_STW || req_op == OP_LDW) && req_addr[1:0] != 2'b00)
            |-> misalign);

    // R9
    rd_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ld_valid);

    // R9
    no_rd_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !ld_valid);

    // R10
    word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr == {req_addr[ADDR_W-1:2], 2'b00});

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_we == '0 && !mem_re && !misalign));

endmodule

bind lsa_aligner lsa_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .misalign  (misalign),
    .ld_valid  (ld_valid)
);

// File: tb/sim_lsa_aligner.sv
`timescale 1ns/1ps
module sim_lsa_aligner;

    localparam logic [31:0] WD   = 32'h1234_5678;
    localparam logic [31:0] RD   = 32'h807F_A55A;
    localparam logic [31:0] BASE = 32'hC000_1230;

    typedef struct packed {
        logic [5:0]  op;
        logic [1:0]  off;
        logic [3:0]  we;
        logic [31:0] ewd;
        logic        mis;
        logic        lv;
        logic [31:0] eld;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{6'h20, 2'd0, 4'b0000, 32'h0,          1'b0, 1'b1, 32'hFFFF_FF80},
        '{6'h20, 2'd1, 4'b0000, 32'h0,          1'b0, 1'b1, 32'h0000_007F},
        '{6'h24, 2'd0, 4'b0000, 32'h0,          1'b0, 1'b1, 32'h0000_0080},
        '{6'h20, 2'd2, 4'b0000, 32'h0,          1'b0, 1'b1, 32'hFFFF_FFA5},
        '{6'h24, 2'd3, 4'b0000, 32'h0,          1'b0, 1'b1, 32'h0000_005A},
        '{6'h21, 2'd0, 4'b0000, 32'h0,          1'b0, 1'b1, 32'hFFFF_807F},
        '{6'h25, 2'd2, 4'b0000, 32'h0,          1'b0, 1'b1, 32'h0000_A55A},
        '{6'h21, 2'd2, 4'b0000, 32'h0,          1'b0, 1'b1, 32'hFFFF_A55A},
        '{6'h25, 2'd0, 4'b0000, 32'h0,          1'b0, 1'b1, 32'h0000_807F},
        '{6'h23, 2'd0, 4'b0000, 32'h0,          1'b0, 1'b1, 32'h807F_A55A},
        '{6'h21, 2'd1, 4'b0000, 32'h0,          1'b1, 1'b0, 32'h0},
        '{6'h23, 2'd2, 4'b0000, 32'h0,          1'b1, 1'b0, 32'h0},
        '{6'h28, 2'd0, 4'b1000, 32'h7878_7878,  1'b0, 1'b0, 32'h0},
        '{6'h28, 2'd3, 4'b0001, 32'h7878_7878,  1'b0, 1'b0, 32'h0},
        '{6'h29, 2'd0, 4'b1100, 32'h5678_5678,  1'b0, 1'b0, 32'h0},
        '{6'h29, 2'd2, 4'b0011, 32'h5678_5678,  1'b0, 1'b0, 32'h0},
        '{6'h2B, 2'd0, 4'b1111, 32'h1234_5678,  1'b0, 1'b0, 32'h0},
        '{6'h29, 2'd3, 4'b0000, 32'h0,          1'b1, 1'b0, 32'h0},
        '{6'h2B, 2'd1, 4'b0000, 32'h0,          1'b1, 1'b0, 32'h0},
        '{6'h22, 2'd0, 4'b0000, 32'h0,          1'b0, 1'b0, 32'h0},
        '{6'h2A, 2'd0, 4'b0000, 32'h0,          1'b0, 1'b0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [5:0]  req_op;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [31:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        mem_re;
    logic        misalign;
    logic [31:0] mem_rdata;
    logic        ld_valid;
    logic [31:0] ld_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lsa_aligner #(.ADDR_W(32), .BYTE_W(8)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .misalign  (misalign),
        .mem_rdata (mem_rdata),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic string tag_of(vec_t v);
        if (v.mis) return "R5";
        case (v.op)
            6'h20, 6'h24: return "R6";
            6'h21, 6'h25: return "R7";
            6'h23:        return "R8";
            6'h28, 6'h29, 6'h2B: return "R3";
            default:      return "R1";
        endcase
    endfunction

    task automatic drive(input logic v, input logic [5:0] op, input logic [31:0] a);
        req_valid = v;
        req_op    = op;
        req_addr  = a;
        req_wdata = WD;
    endtask

    initial begin
        rst_n     = 1'b0;
        mem_rdata = '0;
        drive(1'b0, 6'h00, 32'h0);

        // R12: reset state
        repeat (3) @(negedge clk);
        check(ld_valid == 1'b0, "R12 ld_valid in reset", 32'(ld_valid), 32'h0);
        check(mem_we == 4'b0, "R12 mem_we in reset", 32'(mem_we), 32'h0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            string t = tag_of(v);
            @(negedge clk);
            drive(1'b1, v.op, BASE | 32'(v.off));
            #1;
            check(mem_we == v.we, t, 32'(mem_we), 32'(v.we));
            check(misalign == v.mis, "R5 misalign", 32'(misalign), 32'(v.mis));
            check(mem_re == v.lv, "R10 mem_re", 32'(mem_re), 32'(v.lv));
            if (v.we != 4'b0)
                check(mem_wdata == v.ewd, "R4 wdata", mem_wdata, v.ewd);
            @(negedge clk);
            drive(1'b0, 6'h00, 32'h0);
            mem_rdata = RD;
            #1;
            check(ld_valid == v.lv, "R9 ld_valid", 32'(ld_valid), 32'(v.lv));
            if (v.lv)
                check(ld_data == v.eld, t, ld_data, v.eld);
        end

        // R2: offset 0 is the top byte, for stores and loads
        @(negedge clk);
        drive(1'b1, 6'h28, 32'h0000_0100);
        #1;
        check(mem_we == 4'b1000, "R2 store lane", 32'(mem_we), 32'h8);
        @(negedge clk);
        drive(1'b1, 6'h24, 32'h0000_0100);
        @(negedge clk);
        drive(1'b0, 6'h00, 32'h0);
        mem_rdata = 32'hAB00_0000;
        #1;
        check(ld_data == 32'h0000_00AB, "R2 load lane", ld_data, 32'hAB);

        // R10: word address with upper bits preserved
        @(negedge clk);
        drive(1'b1, 6'h20, 32'hFEDC_BA97);
        #1;
        check(mem_addr == 32'hFEDC_BA94, "R10 mem_addr", mem_addr, 32'hFEDC_BA94);
        check(mem_re == 1'b1, "R10 mem_re", 32'(mem_re), 32'h1);

        // R11: idle request with load/store opcodes is ignored
        @(negedge clk);
        drive(1'b0, 6'h2B, 32'h0000_0000);
        #1;
        check(mem_we == 4'b0, "R11 mem_we idle", 32'(mem_we), 32'h0);
        drive(1'b0, 6'h23, 32'h0000_0002);
        #1;
        check(misalign == 1'b0, "R11 misalign idle", 32'(misalign), 32'h0);
        check(mem_re == 1'b0, "R11 mem_re idle", 32'(mem_re), 32'h0);
        @(negedge clk);
        #1;
        check(ld_valid == 1'b0, "R11 ld_valid after idle", 32'(ld_valid), 32'h0);

        // R9: back-to-back loads keep their own context
        @(negedge clk);
        drive(1'b1, 6'h20, BASE);
        @(negedge clk);
        drive(1'b1, 6'h24, BASE | 32'd3);
        mem_rdata = RD;
        #1;
        check(ld_valid && ld_data == 32'hFFFF_FF80, "R9 first of pair", ld_data, 32'hFFFF_FF80);
        @(negedge clk);
        drive(1'b0, 6'h00, 32'h0);
        mem_rdata = 32'h1122_3344;
        #1;
        check(ld_valid && ld_data == 32'h0000_0044, "R9 second of pair", ld_data, 32'h44);

        // R12: load presented as reset is asserted leaves nothing pending
        @(negedge clk);
        drive(1'b1, 6'h23, BASE);
        rst_n = 1'b0;
        @(negedge clk);
        drive(1'b0, 6'h00, 32'h0);
        rst_n = 1'b1;
        #1;
        check(ld_valid == 1'b0, "R12 ld_valid after reset", 32'(ld_valid), 32'h0);

        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
            summary();
            $finish;
        end
    end

endmodule